// File: doc/BRIEF.md
# Audio coprocessor I/O page decoder

This block sits between a small sound CPU and its 64 KB address space. It watches every bus access and routes it. The routes are the external RAM, a sixteen-byte page of peripheral registers at 0x00F0 to 0x00FF, and a 64-byte boot image mapped over the top of the address space. Reads are combinational in the same cycle. Writes take effect on the next rising clock edge. Strobes to the outside are valid only while the access is presented.

The page gives access to several peripherals:
- A control byte holds the three timer enables and the boot-image map bit. The same byte also carries two port-clear bits, which act for one cycle and are not stored.
- An index byte and a data byte form an indirect window onto a 128-entry DSP register file.
- Four communication bytes are kept in the block.
- Write strobes go to three timer period registers.
- Three 4-bit timer counters can be read. Any access to a counter sends a clear strobe to it.

The top 64 bytes are backed by a shadow store inside the block. Every write there lands in the shadow store. When the boot image is unmapped, reads of that region return the shadow store, and writes to it also reach the external RAM.

Top module: `apu_iopage`

## Requirements
- R1: An access outside the I/O page and outside the mapped boot image goes straight to external RAM. The write strobe `ram_we` follows a write, `cpu_rdata` returns `ram_rdata`, and no peripheral strobe fires.
- R2: Address 0x00F2 is a readable and writable index byte, reset to 0. `dsp_idx` always carries its low 7 bits. A read of 0x00F3 returns `dsp_rdata`, so an index of 0x85 selects DSP register 5.
- R3: A write to 0x00F3 pulses `dsp_we` only while bit 7 of the index byte is 0. Otherwise the write is dropped.
- R4: A write to 0x00F1 loads bits 2:0 into `timer_en`, which resets to 0. Reads of 0x00F0 and 0x00F1 return 0.
- R5: In a write to 0x00F1, bit 4 zeroes communication bytes 0 and 1, and bit 5 zeroes bytes 2 and 3. A later write with those bits at 0 leaves the bytes unchanged.
- R6: Addresses 0x00F4 to 0x00F7 are communication bytes 0 to 3. They reset to 0, can be read and written, and byte k appears on `comm_port[8k+7:8k]`.
- R7: Bit 7 of a 0x00F1 write maps the boot image over 0xFFC0 to 0xFFFF, and the image is mapped after reset. While it is mapped, a read there returns byte (address & 63) of `BOOT_IMG`, that byte sitting at bits [8i+7:8i]. While it is unmapped, such a read returns the shadow store.
- R8: Every write to 0xFFC0 to 0xFFFF updates the shadow store, whichever way the map bit stands. `ram_we` fires for such a write only while the image is unmapped. The shadow store resets to 0.
- R9: A write to 0x00F0 has no effect and raises no strobe. Addresses 0x00F8 and 0x00F9 behave as external RAM.
- R10: A write to 0x00FA + k (k = 0, 1, 2) pulses `tmr_period_we[k]`. Reads of these addresses return 0.
- R11: A read of 0x00FD + k returns `{4'b0, tmr_cnt[4k+3:4k]}`. Any access to that address, read or write, pulses `tmr_cnt_ack[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | Bus access valid this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| ram_we | output | 1 | External RAM write strobe |
| ram_addr | output | 16 | External RAM address |
| ram_wdata | output | 8 | External RAM write data |
| ram_rdata | input | 8 | External RAM read data |
| dsp_idx | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| timer_en | output | 3 | Timer enables |
| tmr_period_we | output | 3 | Timer period write strobes, data on cpu_wdata |
| tmr_cnt | input | 12 | Three 4-bit timer counter values |
| tmr_cnt_ack | output | 3 | Timer counter clear strobes |
| comm_port | output | 32 | Four communication bytes |

## Verification
A single write to the control byte can act on three things in the same edge: it clears communication bytes, it changes the timer enables, and it flips the boot-image map. A write there can also come in the cycle right after a write to a communication byte or to the overlay region.

The random stream mixes these addresses densely with random control values. A reference model in the bench then judges the outcome. It checks the port bytes one cycle later, and it checks the overlay read-back, which must come from the image or from the shadow store according to the new map bit. A directed sequence toggles the map several times around one overlay write to show that the shadow contents survive.

// File: rtl/apu_iopage.sv
module apu_iopage #(
  parameter int AW = 16,
  parameter int OVL_BYTES = 64,
  parameter logic [8*OVL_BYTES-1:0] BOOT_IMG = {8'hFF, 8'hC0, {(8*OVL_BYTES-16){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic [6:0]    dsp_idx,
  output logic          dsp_we,
  output logic [7:0]    dsp_wdata,
  input  logic [7:0]    dsp_rdata,
  output logic [2:0]    timer_en,
  output logic [2:0]    tmr_period_we,
  input  logic [11:0]   tmr_cnt,
  output logic [2:0]    tmr_cnt_ack,
  output logic [31:0]   comm_port
);
  localparam int OAW = $clog2(OVL_BYTES);

  logic [7:0] idx_q;
  logic       rom_on;
  logic [7:0] port_q [4];
  logic [7:0] shadow [OVL_BYTES];

  wire wr = cpu_en & cpu_we;
  wire page_hit = (cpu_addr[AW-1:8] == '0) && (cpu_addr[7:4] == 4'hF);
  wire [3:0] sel = cpu_addr[3:0];
  wire ovl_hit = &cpu_addr[AW-1:OAW];
  wire [OAW-1:0] ovl_off = cpu_addr[OAW-1:0];
  wire ram_hit = page_hit ? (sel == 4'h8 || sel == 4'h9) : !(ovl_hit && rom_on);

  assign ram_we    = wr & ram_hit;
  assign ram_addr  = cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign dsp_idx   = idx_q[6:0];
  assign dsp_wdata = cpu_wdata;
  assign dsp_we    = wr & page_hit & (sel == 4'h3) & ~idx_q[7];

  for (genvar k = 0; k < 3; k++) begin : g_tmr
    assign tmr_period_we[k] = wr & page_hit & (sel == 4'hA + 4'(k));
    assign tmr_cnt_ack[k]   = cpu_en & page_hit & (sel == 4'hD + 4'(k));
  end

  for (genvar k = 0; k < 4; k++) begin : g_port
    assign comm_port[8*k +: 8] = port_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      rom_on   <= 1'b1;
      timer_en <= '0;
      for (int i = 0; i < 4; i++) port_q[i] <= '0;
      for (int i = 0; i < OVL_BYTES; i++) shadow[i] <= '0;
    end else if (wr) begin
      if (ovl_hit) shadow[ovl_off] <= cpu_wdata;
      if (page_hit) begin
        case (sel)
          4'h1: begin
            timer_en <= cpu_wdata[2:0];
            rom_on   <= cpu_wdata[7];
            if (cpu_wdata[4]) begin port_q[0] <= '0; port_q[1] <= '0; end
            if (cpu_wdata[5]) begin port_q[2] <= '0; port_q[3] <= '0; end
          end
          4'h2: idx_q <= cpu_wdata;
          4'h4, 4'h5, 4'h6, 4'h7: port_q[sel[1:0]] <= cpu_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cpu_rdata = ram_rdata;
    if (page_hit) begin
      case (sel)
        4'h0, 4'h1, 4'hA, 4'hB, 4'hC: cpu_rdata = 8'h00;
        4'h2: cpu_rdata = idx_q;
        4'h3: cpu_rdata = dsp_rdata;
        4'h4, 4'h5, 4'h6, 4'h7: cpu_rdata = port_q[sel[1:0]];
        4'hD: cpu_rdata = {4'b0, tmr_cnt[3:0]};
        4'hE: cpu_rdata = {4'b0, tmr_cnt[7:4]};
        4'hF: cpu_rdata = {4'b0, tmr_cnt[11:8]};
        default: cpu_rdata = ram_rdata;
      endcase
    end else if (ovl_hit) begin
      cpu_rdata = rom_on ? BOOT_IMG[8*ovl_off +: 8] : shadow[ovl_off];
    end
  end
endmodule

module apu_iopage_chk #(parameter int AW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_en,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [7:0]    cpu_wdata,
  input logic          ram_we,
  input logic [6:0]    dsp_idx,
  input logic          dsp_we,
  input logic [2:0]    timer_en,
  input logic [2:0]    tmr_period_we,
  input logic [2:0]    tmr_cnt_ack,
  input logic [31:0]   comm_port
);
  wire pg = cpu_en && cpu_addr[AW-1:8] == '0 && cpu_addr[7:4] == 4'hF;

  // R2
  idx_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && cpu_we && cpu_addr[3:0] == 4'h2) |=> dsp_idx == $past(cpu_wdata[6:0]));

  // R4
  tmr_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && cpu_we && cpu_addr[3:0] == 4'h1) |=> timer_en == $past(cpu_wdata[2:0]));

  // R5
  port_lo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && cpu_we && cpu_addr[3:0] == 4'h1 && cpu_wdata[4]) |=> comm_port[15:0] == 16'h0);

  // R1
  plain_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_addr < AW'(16'h00F0)) |-> (!dsp_we && tmr_period_we == 3'b0 && tmr_cnt_ack == 3'b0));

  // R9
  test_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg && cpu_addr[3:0] == 4'h0) |-> (!ram_we && !dsp_we && tmr_period_we == 3'b0));

  // R11
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tmr_cnt_ack));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> ($stable(comm_port) && $stable(timer_en) && $stable(dsp_idx)));
endmodule

bind apu_iopage apu_iopage_chk #(.AW(AW)) u_chk (.*);

// File: tb/apu_iopage_bench.sv
module apu_iopage_bench;
  function automatic logic [511:0] mk_img();
    logic [511:0] v;
    for (int i = 0; i < 64; i++) v[8*i +: 8] = 8'((i * 37 + 11) ^ 8'h5A);
    return v;
  endfunction
  localparam logic [511:0] IMG = mk_img();

  logic clk = 0, rst_n = 0;
  logic cpu_en = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata, ram_wdata, ram_rdata, dsp_wdata, dsp_rdata;
  logic [15:0] ram_addr;
  logic ram_we, dsp_we;
  logic [6:0] dsp_idx;
  logic [2:0] timer_en, tmr_period_we, tmr_cnt_ack;
  logic [11:0] tmr_cnt = 0;
  logic [31:0] comm_port;

  always #5 clk = ~clk;

  assign ram_rdata = ram_addr[15:8] ^ ram_addr[7:0] ^ 8'h3C;
  assign dsp_rdata = {1'b0, dsp_idx} ^ 8'hA6;

  apu_iopage #(.BOOT_IMG(IMG)) u_apu_iopage (.*);

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_idx, m_port [4], m_sh [64];
  logic [2:0] m_ten;
  logic m_rom;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_page(logic [15:0] a); return a[15:4] == 12'h00F; endfunction
  function automatic bit in_ovl(logic [15:0] a);  return a[15:6] == 10'h3FF; endfunction

  function automatic string tag_of(logic [15:0] a, logic we);
    if (in_ovl(a)) return we ? "R8" : "R7";
    if (!in_page(a)) return "R1";
    case (a[3:0])
      4'h0, 4'h8, 4'h9: return "R9";
      4'h1: return "R4/R5";
      4'h2: return "R2";
      4'h3: return we ? "R3" : "R2";
      4'hA, 4'hB, 4'hC: return "R10";
      4'hD, 4'hE, 4'hF: return "R11";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    if (in_ovl(a)) return m_rom ? IMG[8*a[5:0] +: 8] : m_sh[a[5:0]];
    if (!in_page(a)) return a[15:8] ^ a[7:0] ^ 8'h3C;
    case (a[3:0])
      4'h2: return m_idx;
      4'h3: return {1'b0, m_idx[6:0]} ^ 8'hA6;
      4'h4, 4'h5, 4'h6, 4'h7: return m_port[a[1:0]];
      4'h8, 4'h9: return a[15:8] ^ a[7:0] ^ 8'h3C;
      4'hD: return {4'b0, tmr_cnt[3:0]};
      4'hE: return {4'b0, tmr_cnt[7:4]};
      4'hF: return {4'b0, tmr_cnt[11:8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic en, input logic we, input logic [15:0] a, input logic [7:0] d);
    string t;
    logic e_ram, e_dsp;
    logic [2:0] e_per, e_ack;
    @(negedge clk);
    cpu_en = en; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    tmr_cnt = 12'($urandom);
    #1;
    t = tag_of(a, we);
    e_ram = en && we && (in_page(a) ? (a[3:0] == 4'h8 || a[3:0] == 4'h9) : !(in_ovl(a) && m_rom));
    e_dsp = en && we && in_page(a) && a[3:0] == 4'h3 && !m_idx[7];
    e_per = '0; e_ack = '0;
    for (int k = 0; k < 3; k++) begin
      if (en && we && in_page(a) && a[3:0] == 4'hA + 4'(k)) e_per[k] = 1'b1;
      if (en && in_page(a) && a[3:0] == 4'hD + 4'(k)) e_ack[k] = 1'b1;
    end
    if (en && !we) chk(cpu_rdata == exp_rd(a), t, cpu_rdata, exp_rd(a));
    chk(ram_we == e_ram, t, ram_we, e_ram);
    chk(dsp_we == e_dsp, t, dsp_we, e_dsp);
    chk(tmr_period_we == e_per, t, tmr_period_we, e_per);
    chk(tmr_cnt_ack == e_ack, t, tmr_cnt_ack, e_ack);
    chk(dsp_idx == m_idx[6:0], "R2", dsp_idx, m_idx[6:0]);
    @(posedge clk);
    if (en && we) begin
      if (in_ovl(a)) m_sh[a[5:0]] = d;
      if (in_page(a)) case (a[3:0])
        4'h1: begin
          m_ten = d[2:0]; m_rom = d[7];
          if (d[4]) begin m_port[0] = 0; m_port[1] = 0; end
          if (d[5]) begin m_port[2] = 0; m_port[3] = 0; end
        end
        4'h2: m_idx = d;
        4'h4, 4'h5, 4'h6, 4'h7: m_port[a[1:0]] = d;
        default: ;
      endcase
    end
    #1;
    chk(timer_en == m_ten, "R4", timer_en, m_ten);
    chk(comm_port == {m_port[3], m_port[2], m_port[1], m_port[0]}, "R5/R6",
        comm_port, {m_port[3], m_port[2], m_port[1], m_port[0]});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    m_idx = 0; m_ten = 0; m_rom = 1;
    for (int i = 0; i < 4; i++) m_port[i] = 0;
    for (int i = 0; i < 64; i++) m_sh[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(timer_en == 0, "R4 reset", timer_en, 0);
    chk(comm_port == 0, "R6 reset", comm_port, 0);
    chk(dsp_idx == 0, "R2 reset", dsp_idx, 0);

    // R2 index masking, R3 dropped high-index write
    step(1, 1, 16'h00F2, 8'h85);
    step(1, 0, 16'h00F3, 8'h00);
    step(1, 1, 16'h00F3, 8'h42);
    step(1, 0, 16'h00F2, 8'h00);
    step(1, 1, 16'h00F2, 8'h7F);
    step(1, 1, 16'h00F3, 8'h11);
    // R6 then R5 strobe-only clears
    for (int k = 0; k < 4; k++) step(1, 1, 16'h00F4 + 16'(k), 8'hC0 + 8'(k));
    step(1, 1, 16'h00F1, 8'h93);
    step(1, 1, 16'h00F4, 8'h5E);
    step(1, 1, 16'h00F1, 8'h80);
    step(1, 1, 16'h00F1, 8'hA5);
    for (int k = 0; k < 4; k++) step(1, 0, 16'h00F4 + 16'(k), 8'h00);
    // R7 / R8 shadow survives overlay toggles
    step(1, 1, 16'hFFC5, 8'h77);
    step(1, 0, 16'hFFC5, 8'h00);
    step(1, 1, 16'h00F1, 8'h00);
    step(1, 0, 16'hFFC5, 8'h00);
    step(1, 1, 16'hFFFF, 8'h19);
    step(1, 1, 16'h00F1, 8'h80);
    step(1, 0, 16'hFFFF, 8'h00);
    step(1, 1, 16'h00F1, 8'h07);
    step(1, 0, 16'hFFC5, 8'h00);
    step(1, 0, 16'hFFFF, 8'h00);
    // R9, R10, R11, R1
    step(1, 1, 16'h00F0, 8'hFF);
    step(1, 0, 16'h00F0, 8'h00);
    step(1, 1, 16'h00F8, 8'h12);
    step(1, 0, 16'h00F9, 8'h00);
    step(1, 1, 16'h00FB, 8'h40);
    step(1, 0, 16'h00FA, 8'h00);
    step(1, 0, 16'h00FE, 8'h00);
    step(1, 1, 16'h00FF, 8'h00);
    step(1, 1, 16'h00EF, 8'h33);
    step(1, 0, 16'h0100, 8'h00);
    step(0, 1, 16'h00F1, 8'h30);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int r = $urandom_range(0, 9);
      if (r < 4) a = 16'h00F0 | 16'($urandom_range(0, 15));
      else if (r < 7) a = 16'hFFC0 | 16'($urandom_range(0, 63));
      else a = 16'($urandom);
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, 8'($urandom));
    end
    summary();
  end
endmodule